// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. Every enabled clock cycle can carry a read, a write, a burst step or nothing. Reads and writes may follow each other in any order with no idle cycle between them. Address, byte mask, direction and chip selects are registered on the rising edge. Write data follows its address by two enabled cycles, and read data comes out two enabled cycles after its address. Because of this late-write pipeline, a read issued directly behind a write sees the pending write data.

One command loads a four-beat burst and starts it. Later step commands walk a 2-bit beat counter, in interleaved or linear order. A clock-enable input freezes the whole block for a cycle. Three chip-select inputs, of mixed polarity, all have to agree before a new command is taken, so several devices can share a bus to add depth. The shared bidirectional data bus is split into an input, an output and an output enable. The storage array is small and its size is set by parameters.

Top module: `nws_sram`

## Requirements
- R1: A read loaded at an enabled edge puts the addressed word on `dq_out`, with `dq_oe` high, right after the second enabled edge that follows.
- R2: A write's data is taken from `dq_in` at the second enabled edge after its address. Lane i covers bits [9i+8:9i] and is written only when `bw_n[i]` was low in the address cycle.
- R3: Reads and writes may alternate on consecutive cycles with no idle cycle. A read that directly follows a write to the same address returns the written lanes merged with the older contents of the other lanes.
- R4: A load (`step`=0) starts a new operation only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other select pattern gives a no-op and ends any running burst.
- R5: A step (`step`=1) after an accepted load issues the next burst beat in the direction of that load, with chip selects and `wr_n` ignored. Each beat takes `bw_n` from its own cycle. A step with no running burst is a no-op.
- R6: With `lin`=0 at load, beat k uses low address bits start XOR k. With `lin`=1, it uses (start + k) mod 4. Upper address bits stay fixed, and the counter wraps after four beats.
- R7: While `cke` is low, nothing changes: outputs hold, `dq_in` is not sampled and the array is not written.
- R8: After the edge that completes a write or a no-op, `dq_oe` is low and `dq_out` is zero.
- R9: While `rst_n` is low, `dq_oe` is 0, `dq_out` is 0, and no operation or burst is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| step | input | 1 | 1 = advance burst, 0 = load new address |
| wr_n | input | 1 | 0 = write, 1 = read (used on loads) |
| lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Active-low byte-lane write enables |
| dq_in | input | LANES*LANE_W | Bus data into the block |
| dq_out | output | LANES*LANE_W | Bus data driven by the block |
| dq_oe | output | 1 | Output driver enable |

## Verification
The bench first fills the array with back-to-back full-word writes and reads every word back. This separates wrong latency from wrong storage. Dense alternation of reads and writes over only four addresses, with random lane masks, exercises the bypass of a write still in flight, which only a same-address hazard can reveal. Interleaved and linear bursts are written and then read back one word at a time, so an error in beat order lands data at a wrong address. Random select patterns and random `cke` stalls in the middle of traffic show whether deselects and stalls leave the pipeline and the array untouched.

// File: rtl/nws_pkg.sv
package nws_pkg;

   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } burst_ord_e;

   // low two address bits for beat number 'beat' of a burst starting at 'start'
   function automatic logic [1:0] beat_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input burst_ord_e ord);
      logic [1:0] r;
      if (ord == ORD_LINEAR) r = start + beat;
      else                   r = start ^ beat;
      return r;
   endfunction

endpackage

// File: rtl/nws_cmd_stage.sv
module nws_cmd_stage
   import nws_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              sel_ok,
   input  logic              step,
   input  logic              wr_n,
   input  logic              lin,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  bw_n,
   output logic              s1_valid,
   output logic              s1_write,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [LANES-1:0]  s1_mask
);

   logic              burst_on;
   logic              burst_wr;
   burst_ord_e        burst_ord;
   logic [ADDR_W-1:0] burst_base;
   logic [1:0]        beat_cnt;
   logic [1:0]        beat_nx;
   logic [ADDR_W-1:0] step_addr;

   assign beat_nx   = beat_cnt + 2'd1;
   assign step_addr = {burst_base[ADDR_W-1:2], beat_low(burst_base[1:0], beat_nx, burst_ord)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_on   <= 1'b0;
         burst_wr   <= 1'b0;
         burst_ord  <= ORD_INTERLEAVE;
         burst_base <= '0;
         beat_cnt   <= '0;
         s1_valid   <= 1'b0;
         s1_write   <= 1'b0;
         s1_addr    <= '0;
         s1_mask    <= '0;
      end else if (cke) begin
         if (!step) begin
            if (sel_ok) begin
               burst_on   <= 1'b1;
               burst_wr   <= !wr_n;
               burst_ord  <= burst_ord_e'(lin);
               burst_base <= addr;
               beat_cnt   <= '0;
               s1_valid   <= 1'b1;
               s1_write   <= !wr_n;
               s1_addr    <= addr;
               s1_mask    <= ~bw_n;
            end else begin
               burst_on <= 1'b0;
               s1_valid <= 1'b0;
               s1_write <= 1'b0;
            end
         end else if (burst_on) begin
            beat_cnt <= beat_nx;
            s1_valid <= 1'b1;
            s1_write <= burst_wr;
            s1_addr  <= step_addr;
            s1_mask  <= ~bw_n;
         end else begin
            s1_valid <= 1'b0;
            s1_write <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nws_lane_array.sv
module nws_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES-1:0]        wmask,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wmask[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
      end

      assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
   end

endmodule

// File: rtl/nws_fwd_merge.sv
module nws_fwd_merge #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    hit,
   input  logic [LANES-1:0]        mask,
   input  logic [LANES*LANE_W-1:0] arr_data,
   input  logic [LANES*LANE_W-1:0] new_data,
   output logic [LANES*LANE_W-1:0] merged
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*LANE_W +: LANE_W] = (hit && mask[l]) ? new_data[l*LANE_W +: LANE_W]
                                                          : arr_data[l*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/nws_sram.sv
module nws_sram
   import nws_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    step,
   input  logic                    wr_n,
   input  logic                    lin,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        bw_n,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("nws_sram: ADDR_W must be at least 3 to hold a 4-beat burst");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("nws_sram: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("nws_sram: LANE_W must be at least 1");
   end

   logic              sel_ok;
   logic              s1_valid, s1_write;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_mask;

   logic              s2_valid, s2_write;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_mask;
   logic [DATA_W-1:0] s2_rdata;

   logic              commit;
   logic              fwd_hit;
   logic [DATA_W-1:0] arr_rd;
   logic [DATA_W-1:0] fwd_rd;

   assign sel_ok  = !sel_a_n && sel_b && !sel_c_n;
   assign commit  = cke && s2_valid && s2_write;
   assign fwd_hit = s2_valid && s2_write && (s2_addr == s1_addr);

   nws_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .sel_ok   (sel_ok),
      .step     (step),
      .wr_n     (wr_n),
      .lin      (lin),
      .addr     (addr),
      .bw_n     (bw_n),
      .s1_valid (s1_valid),
      .s1_write (s1_write),
      .s1_addr  (s1_addr),
      .s1_mask  (s1_mask)
   );

   nws_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk   (clk),
      .we    (commit),
      .waddr (s2_addr),
      .wmask (s2_mask),
      .wdata (dq_in),
      .raddr (s1_addr),
      .rdata (arr_rd)
   );

   nws_fwd_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_fwd (
      .hit      (fwd_hit),
      .mask     (s2_mask),
      .arr_data (arr_rd),
      .new_data (dq_in),
      .merged   (fwd_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_write <= 1'b0;
         s2_addr  <= '0;
         s2_mask  <= '0;
         s2_rdata <= '0;
         dq_oe    <= 1'b0;
         dq_out   <= '0;
      end else if (cke) begin
         s2_valid <= s1_valid;
         s2_write <= s1_write;
         s2_addr  <= s1_addr;
         s2_mask  <= s1_mask;
         s2_rdata <= fwd_rd;
         dq_oe    <= s2_valid && !s2_write;
         dq_out   <= (s2_valid && !s2_write) ? s2_rdata : '0;
      end
   end

endmodule

// File: rtl/nws_checker.sv
module nws_checker #(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic              step,
   input logic              wr_n,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe
);

   logic sel_ok;
   assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

   // R1: accepted read load is driven out after two further enabled edges
   p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !step && sel_ok && wr_n) ##1 cke ##1 cke |=> dq_oe);

   // R8: accepted write load never drives the bus
   p_write_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !step && sel_ok && !wr_n) ##1 cke ##1 cke |=> !dq_oe);

   // R4: deselected load produces no drive
   p_deselect_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !step && !sel_ok) ##1 cke ##1 cke |=> !dq_oe);

   // R7: stalled edge holds outputs
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(dq_oe) && $stable(dq_out)));

   // R8: released bus carries zero
   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dq_out == '0));

endmodule

bind nws_sram nws_checker #(.DATA_W(LANES*LANE_W)) u_nws_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cke     (cke),
   .sel_a_n (sel_a_n),
   .sel_b   (sel_b),
   .sel_c_n (sel_c_n),
   .step    (step),
   .wr_n    (wr_n),
   .dq_out  (dq_out),
   .dq_oe   (dq_oe)
);

// File: tb/nws_sram_tb_top.sv
`timescale 1ns/1ps
module nws_sram_tb_top;

   localparam int AW    = 6;
   localparam int NL    = 4;
   localparam int LW    = 9;
   localparam int DW    = NL * LW;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke = 1'b1;
   logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic          step = 1'b0, wr_n = 1'b1, lin = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NL-1:0] bw_n = '1;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   always #2 clk = ~clk;

   nws_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cke(cke), .sel_a_n(sel_a_n), .sel_b(sel_b),
      .sel_c_n(sel_c_n), .step(step), .wr_n(wr_n), .lin(lin), .addr(addr),
      .bw_n(bw_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   typedef struct {
      bit          v;
      bit          w;
      int          a;
      bit [NL-1:0] m;
   } mop_t;

   mop_t          pipe[$];
   logic [DW-1:0] mem [WORDS];
   bit            m_on, m_wr, m_lin;
   int            m_base, m_cnt;
   bit            exp_oe;
   logic [DW-1:0] exp_dq;
   int            n_checks = 0, n_fail = 0;
   string         tag = "R9";
   bit            finished = 0;

   function automatic logic [DW-1:0] rnd_word();
      logic [63:0] t;
      t = {$urandom(), $urandom()};
      return t[DW-1:0];
   endfunction

   task automatic model_reset();
      pipe.delete();
      for (int i = 0; i < 2; i++) pipe.push_back('{v:0, w:0, a:0, m:'0});
      m_on = 0; m_wr = 0; m_lin = 0; m_base = 0; m_cnt = 0;
      exp_oe = 0; exp_dq = '0;
   endtask

   // reference behaviour at one enabled edge, from the requirements
   task automatic model_edge();
      mop_t old, nw;
      bit   ok;
      int   low;
      old = pipe.pop_front();
      if (old.v && old.w)
         for (int l = 0; l < NL; l++)
            if (old.m[l]) mem[old.a][l*LW +: LW] = dq_in[l*LW +: LW];
      exp_oe = old.v && !old.w;
      exp_dq = exp_oe ? mem[old.a] : '0;
      nw = '{v:0, w:0, a:0, m:'0};
      ok = !sel_a_n && sel_b && !sel_c_n;
      if (!step) begin
         if (ok) begin
            nw = '{v:1, w:!wr_n, a:int'(addr), m:~bw_n};
            m_on = 1; m_wr = !wr_n; m_lin = lin; m_base = int'(addr); m_cnt = 0;
         end else m_on = 0;
      end else if (m_on) begin
         m_cnt = (m_cnt + 1) % 4;
         low = m_lin ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
         nw = '{v:1, w:m_wr, a:(m_base & ~3) | low, m:~bw_n};
      end
      pipe.push_back(nw);
   endtask

   task automatic compare();
      n_checks++;
      if (dq_oe !== exp_oe || dq_out !== exp_dq) begin
         n_fail++;
         $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
                  tag, dq_oe, dq_out, exp_oe, exp_dq);
      end
   endtask

   task automatic cycle(input bit c, input bit s, input bit [2:0] sel, input bit w,
                        input bit l, input int a, input bit [NL-1:0] b);
      cke = c; step = s; {sel_a_n, sel_b, sel_c_n} = sel; wr_n = w; lin = l;
      addr = AW'(a); bw_n = b; dq_in = rnd_word();
      @(posedge clk);
      if (c) model_edge();
      @(negedge clk);
      compare();
   endtask

   localparam bit [2:0] SEL_ON = 3'b010;

   task automatic ld(input bit w, input int a, input bit [NL-1:0] b, input bit l);
      cycle(1, 0, SEL_ON, w, l, a, b);
   endtask

   task automatic stp();
      cycle(1, 1, 3'($urandom), 1'($urandom), 1'($urandom), int'($urandom % WORDS), NL'($urandom));
   endtask

   task automatic idle();
      cycle(1, 0, 3'b111, 1, 0, 0, '1);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R9: outputs quiet during reset
      tag = "R9";
      n_checks++;
      if (dq_oe !== 1'b0 || dq_out !== '0) begin
         n_fail++;
         $display("FAIL R9: dq_oe=%0b dq_out=%h expected dq_oe=0 dq_out=0", dq_oe, dq_out);
      end
      rst_n = 1'b1;
      idle(); idle();

      // R2: back-to-back full-word writes fill the array
      tag = "R2";
      for (int i = 0; i < WORDS; i++) ld(0, i, '0, 0);
      // R1: read every word back, no gaps
      tag = "R1";
      for (int i = 0; i < WORDS; i++) ld(1, i, '1, 0);
      idle(); idle();

      // R3: dense read/write alternation on few addresses with lane masks
      tag = "R3";
      for (int i = 0; i < 300; i++) ld(1'($urandom), int'($urandom % 4), NL'($urandom), 0);
      idle(); idle();

      // R8: write streams then reads, bus released on writes
      tag = "R8";
      for (int i = 0; i < 20; i++) ld(0, i, NL'($urandom), 0);
      for (int i = 0; i < 20; i++) ld(1, i, '1, 0);
      idle(); idle();

      // R6: bursts in both orders, both directions, with wrap past four beats
      tag = "R6";
      for (int k = 0; k < 16; k++) begin
         int base = int'($urandom % WORDS);
         bit ord = k[0];
         ld(0, base, '0, ord);
         for (int j = 0; j < 5; j++) stp();
         // read back each word of the quad individually
         for (int j = 0; j < 4; j++) ld(1, (base & ~3) | j, '1, 0);
         ld(1, base, '1, ord);
         for (int j = 0; j < 3; j++) stp();
      end
      idle(); idle();

      // R5: steps with no running burst do nothing; a deselect ends a burst
      tag = "R5";
      idle();
      for (int j = 0; j < 4; j++) stp();
      ld(1, 8, '1, 1);
      stp();
      idle();
      for (int j = 0; j < 4; j++) stp();
      idle(); idle();

      // R4: random select patterns on loads
      tag = "R4";
      for (int i = 0; i < 200; i++)
         cycle(1, 0, 3'($urandom), 1'($urandom), 0, int'($urandom % 8), NL'($urandom));
      idle(); idle();

      // R7: random stalls in mixed traffic, bursts included
      tag = "R7";
      for (int i = 0; i < 400; i++)
         cycle(($urandom % 4) != 0, ($urandom % 3) == 0, (($urandom % 4) == 0) ? 3'($urandom) : SEL_ON,
               1'($urandom), 1'($urandom), int'($urandom % 8), NL'($urandom));
      idle(); idle();
      tag = "R1";
      for (int i = 0; i < 8; i++) ld(1, i, '1, 0);
      idle(); idle(); idle();

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule